// File: doc/BRIEF.md
# DMA Transfer Command and Verify Timer

This block produces the per-transfer bus commands for one DMA channel. A one-clock start pulse latches a transfer type and a service mode. The block then asserts the channel acknowledge and, for a real transfer, the I/O strobe and the memory-direction controls. A write moves data from I/O to memory, so the I/O read strobe is driven with a memory-write indication. A read moves data from memory to I/O, so the I/O write strobe is driven with a memory-read indication.

A verify transfer is a pseudo transfer. It drives no strobe and no memory control, only the acknowledge. An internal clock counter sets the acknowledge width: nine clocks for the first transfer and eight more for each repeat. The acknowledge stays high without a gap across repeats.

At the end of every transfer interval the block pulses `advance`, which steps the external address and count logic. When that logic reports the last transfer, the block also pulses `tc`. Single mode stops after one transfer. Block mode repeats until the terminal count. Demand mode also stops at the first interval end where the request is low.

Top module: `dma_xfer_cmd_gen`

## Requirements
- R1: After reset every output is low and stays low until a start pulse is sampled.
- R2: Type code 01 (write) holds `mem_cyc` and `mem_wr` high for the whole transfer and pulses `io_rd` for the first CMD_CLKS-1 clocks of each CMD_CLKS-clock transfer. `io_wr` stays low throughout.
- R3: Type code 10 (read) holds `mem_cyc` high and `mem_wr` low, and pulses `io_wr` with the same timing as R2. `io_rd` stays low throughout.
- R4: Type code 00 (verify) asserts `dack` only: `io_rd`, `io_wr`, `mem_cyc` and `mem_wr` stay low.
- R5: The first verify transfer holds `dack` for exactly FIRST_CLKS (9) clocks starting the clock after start, with `advance` high in its final clock only.
- R6: Each repeated verify transfer lasts REPEAT_CLKS (8) clocks, and `dack` never drops between repeats. In block mode (mode code 01), repeats continue until an interval end at which `cnt_last` is high.
- R7: In demand mode (mode code 10), the sequence ends at an interval end where `dreq` is low, and `dack` falls on the next clock.
- R8: `tc` is high exactly in an `advance` clock where `cnt_last` is high, and that ends the sequence in every mode.
- R9: Type code 11 is reserved and behaves exactly like verify.
- R10: A start pulse while `dack` is high is ignored: the running transfer's type, timing and outputs are unchanged.
- R11: Mode code 00 (single) and the reserved code 11 both end after one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin service |
| xfer_type | input | 2 | 00 verify, 01 write, 10 read, 11 verify |
| xfer_mode | input | 2 | 00 single, 01 block, 10 demand, 11 single |
| dreq | input | 1 | Channel request level, used in demand mode |
| cnt_last | input | 1 | Count logic reports that the current transfer is the final one |
| dack | output | 1 | Channel acknowledge |
| io_rd | output | 1 | I/O read strobe (write transfers) |
| io_wr | output | 1 | I/O write strobe (read transfers) |
| mem_cyc | output | 1 | Memory cycle indication |
| mem_wr | output | 1 | Memory direction: 1 write, 0 read |
| advance | output | 1 | End-of-transfer step pulse for address and count logic |
| tc | output | 1 | Terminal count pulse |

## Verification
The interval-end step and the stop decision always fall in the same clock. At that edge, a terminal count, a dropped demand request and the repeat reload all compete. The bench provokes this with demand runs where `dreq` falls before `cnt_last` and others where `cnt_last` arrives first. A per-cycle scoreboard checks that `advance`, `tc` and the fall of `dack` line up with the chosen transfer count. A second collision is a start pulse landing mid-transfer. It is judged by the unchanged per-cycle outputs of the running transfer.

// File: rtl/dma_xfer_cmd_gen.sv
module dma_xfer_cmd_gen #(
  parameter int FIRST_CLKS  = 9,
  parameter int REPEAT_CLKS = 8,
  parameter int CMD_CLKS    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] xfer_type,
  input  logic [1:0] xfer_mode,
  input  logic       dreq,
  input  logic       cnt_last,
  output logic       dack,
  output logic       io_rd,
  output logic       io_wr,
  output logic       mem_cyc,
  output logic       mem_wr,
  output logic       advance,
  output logic       tc
);
  localparam int MAXC = (FIRST_CLKS > REPEAT_CLKS) ?
                        ((FIRST_CLKS > CMD_CLKS) ? FIRST_CLKS : CMD_CLKS) :
                        ((REPEAT_CLKS > CMD_CLKS) ? REPEAT_CLKS : CMD_CLKS);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FIRST_LD  = CW'(FIRST_CLKS - 1);
  localparam logic [CW-1:0] REPEAT_LD = CW'(REPEAT_CLKS - 1);
  localparam logic [CW-1:0] CMD_LD    = CW'(CMD_CLKS - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [1:0]    typ_q;
  logic [1:0]    mode_q;

  wire is_wr    = (typ_q == 2'b01);
  wire is_rd    = (typ_q == 2'b10);
  wire is_ver   = !is_wr && !is_rd;
  wire in_ver   = !(xfer_type == 2'b01 || xfer_type == 2'b10);
  wire repeat_ok = (mode_q == 2'b01) || (mode_q == 2'b10 && dreq);
  wire more     = advance && !cnt_last && repeat_ok;
  wire strobe   = active && !is_ver && (cnt != '0);

  assign advance = active && (cnt == '0);
  assign tc      = advance && cnt_last;
  assign dack    = active;
  assign io_rd   = strobe && is_wr;
  assign io_wr   = strobe && is_rd;
  assign mem_cyc = active && !is_ver;
  assign mem_wr  = active && is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      typ_q  <= 2'b00;
      mode_q <= 2'b00;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        typ_q  <= xfer_type;
        mode_q <= xfer_mode;
        cnt    <= in_ver ? FIRST_LD : CMD_LD;
      end
    end else if (advance) begin
      if (more) cnt <= is_ver ? REPEAT_LD : CMD_LD;
      else      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dma_xfer_cmd_gen_chk.sv
module dma_xfer_cmd_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] xfer_type,
  input logic [1:0] typ_q,
  input logic [1:0] mode_q,
  input logic       dack,
  input logic       io_rd,
  input logic       io_wr,
  input logic       mem_cyc,
  input logic       mem_wr,
  input logic       advance,
  input logic       tc
);
  wire ver_q = !(typ_q == 2'b01 || typ_q == 2'b10);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(io_rd && io_wr)); // R2
  AST_CMD_NEEDS_DACK: assert property (@(posedge clk) disable iff (!rst_n) (io_rd || io_wr || mem_cyc || mem_wr) |-> dack); // R3
  AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (dack && ver_q) |-> (!io_rd && !io_wr && !mem_cyc && !mem_wr)); // R4
  AST_DACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dack && !advance) |=> dack); // R6
  AST_TC_IN_ADV: assert property (@(posedge clk) disable iff (!rst_n) tc |-> advance); // R8
  AST_TC_ENDS: assert property (@(posedge clk) disable iff (!rst_n) tc |=> !dack); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (dack && start) |=> $stable(typ_q)); // R10
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (advance && (mode_q == 2'b00 || mode_q == 2'b11)) |=> !dack); // R11
endmodule

bind dma_xfer_cmd_gen dma_xfer_cmd_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .xfer_type(xfer_type),
  .typ_q(typ_q), .mode_q(mode_q), .dack(dack), .io_rd(io_rd),
  .io_wr(io_wr), .mem_cyc(mem_cyc), .mem_wr(mem_wr),
  .advance(advance), .tc(tc)
);

// File: tb/sim_dma_xfer_cmd_gen.sv
module sim_dma_xfer_cmd_gen;
  localparam int CLK_PERIOD = 10;
  localparam int FIRST = 9, REP = 8, CMD = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dreq = 1'b0, cnt_last = 1'b0;
  logic [1:0] xfer_type = 2'b00, xfer_mode = 2'b00;
  logic dack, io_rd, io_wr, mem_cyc, mem_wr, advance, tc;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [6:0] v; string req; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_cmd_gen #(.FIRST_CLKS(FIRST), .REPEAT_CLKS(REP), .CMD_CLKS(CMD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_type(xfer_type),
    .xfer_mode(xfer_mode), .dreq(dreq), .cnt_last(cnt_last), .dack(dack),
    .io_rd(io_rd), .io_wr(io_wr), .mem_cyc(mem_cyc), .mem_wr(mem_wr),
    .advance(advance), .tc(tc));

  wire [6:0] obs = {dack, io_rd, io_wr, mem_cyc, mem_wr, advance, tc};

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(obs, it.v, it.req);
    end
  end

  // ty/md codes; nlast = transfer index (1-based) with cnt_last; d = demand transfer during which dreq is low
  task automatic run(input logic [1:0] ty, input logic [1:0] md, input int nlast,
                     input int d, input bit poke, input string req);
    bit wr = (ty == 2'b01);
    bit rd = (ty == 2'b10);
    bit real_x = wr || rd;
    int nx;
    if (md == 2'b01)      nx = nlast;
    else if (md == 2'b10) nx = (d < nlast) ? d : nlast;
    else                  nx = 1;
    @(negedge clk);
    start = 1'b1; xfer_type = ty; xfer_mode = md;
    @(posedge clk); #1;
    start = 1'b0;
    for (int j = 0; j < nx; j++) begin
      int len = real_x ? CMD : ((j == 0) ? FIRST : REP);
      for (int c = 0; c < len; c++) begin
        item_t it;
        bit adv = (c == len - 1);
        bit stb = real_x && (c < len - 1);
        dreq = (j < d - 1);
        cnt_last = (j == nlast - 1);
        if (poke && j == 0 && c == 2) begin
          start = 1'b1; xfer_type = 2'b10; xfer_mode = 2'b01;
        end else begin
          start = 1'b0;
        end
        it.v = {1'b1, stb && wr, stb && rd, real_x, wr, adv, adv && (j == nlast - 1)};
        it.req = req;
        sb.push_back(it);
        @(posedge clk); #1;
      end
    end
    start = 1'b0; cnt_last = 1'b0; dreq = 1'b0;
    begin
      item_t it;
      it.v = 7'b0; it.req = req;
      sb.push_back(it);
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: outputs %b expected completion", obs);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(obs, 7'b0, "R1 reset");
    repeat (2) @(negedge clk);
    check(obs, 7'b0, "R1 idle");
    run(2'b01, 2'b00, 1, 9, 1'b0, "R2 write single");
    run(2'b10, 2'b00, 1, 9, 1'b0, "R3 read single");
    run(2'b00, 2'b00, 1, 9, 1'b0, "R4 R5 verify single");
    run(2'b00, 2'b01, 3, 9, 1'b0, "R6 R8 verify block");
    run(2'b00, 2'b10, 5, 2, 1'b0, "R7 verify demand dreq drop");
    run(2'b00, 2'b10, 2, 9, 1'b0, "R8 verify demand tc first");
    run(2'b11, 2'b00, 1, 9, 1'b0, "R9 reserved type");
    run(2'b11, 2'b01, 2, 9, 1'b0, "R9 reserved type block");
    run(2'b01, 2'b01, 2, 9, 1'b0, "R2 write block");
    run(2'b00, 2'b00, 1, 9, 1'b1, "R10 start while busy");
    run(2'b00, 2'b11, 3, 9, 1'b0, "R11 reserved mode single");
    run(2'b10, 2'b10, 9, 3, 1'b0, "R3 R7 read demand");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule